// File: doc/BRIEF.md
# Staggered Three-Unit Window Despreader

This block recovers soft QPSK symbols from a short-code direct-sequence CDMA chip stream. Every symbol decision looks at three symbol periods of complex chip samples, the previous, the current and the next. That is a window of 3L samples, where L is the number of chips per symbol. Each decision is the inner product of that window with a complex coefficient vector. The vector has two parts. The first is a fixed anchor: the user's spreading code, scaled by a constant and placed in the middle third of the window. The second is an adaptive part held in a writable register array.

A single correlator would yield only one decision per three symbols. The block therefore runs three identical correlators, each starting its window one symbol after the previous one. Each correlator finishes one window every three symbols, and the finish points are one symbol apart. The finished results are handed out in turn, unit 0, then 1, then 2, so one soft symbol leaves the block per symbol period. Each soft symbol is tagged with the index of the unit that produced it.

The accumulation runs at full word length, so the sum is never rounded. A one-bit rounding applied repeatedly with a code that is not balanced would build a bias aligned with the code.

Top module: `window_despreader`

## Requirements
- R1: While rst_ni is low, sym_valid_o is low and sym_re_o, sym_im_o are zero; the adaptive coefficients are cleared to zero.
- R2: No soft symbol is produced until 3L chips have been accepted since reset; the first one follows the 3L-th accepted chip.
- R3: Each soft symbol equals sum over window positions p of conj(h_p)·y_p at full precision: re = Σ(hr·yr + hi·yq), im = Σ(hr·yq − hi·yr). Position 0 is the oldest chip of the window. There is no truncation or wrap, even with all-extreme samples and coefficients.
- R4: Soft symbols are produced by unit 0, 1, 2, 0, … in that order, one per symbol. sym_unit_o carries the unit index (0..2, never 3). The window ending with symbol s (s ≥ 2, counting from 0 after reset) comes from unit (s−2) mod 3.
- R5: The effective coefficient at position p is the adaptive value plus an anchor term. For L ≤ p < 2L the anchor adds +ANCHOR to the real part when code_i[p−L] is 0 and −ANCHOR when it is 1. The outer thirds get no anchor term.
- R6: A write with coef_we_i high and coef_addr_i = p < 3L sets the adaptive real and imaginary values of window position p. These values apply to chips accepted after the write cycle.
- R7: Cycles with chip_valid_i low change no state. The following cycle shows no soft symbol, and gaps between chips do not alter any result.
- R8: sym_valid_o is a one-cycle pulse. It is asserted in the cycle after the clock edge that accepts the last chip of a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| chip_valid_i | input | 1 | Chip sample strobe |
| chip_re_i | input | SAMP_W | Signed in-phase chip sample |
| chip_im_i | input | SAMP_W | Signed quadrature chip sample |
| code_i | input | L | Signature chips, bit 0 → +1, bit 1 → −1 |
| coef_we_i | input | 1 | Adaptive coefficient write enable |
| coef_addr_i | input | $clog2(3L) | Window position to write |
| coef_re_i | input | COEF_W | Signed adaptive real part |
| coef_im_i | input | COEF_W | Signed adaptive imaginary part |
| sym_valid_o | output | 1 | Soft symbol strobe |
| sym_re_o | output | ACC_W | Signed soft symbol, real |
| sym_im_o | output | ACC_W | Signed soft symbol, imaginary |
| sym_unit_o | output | 2 | Index of the producing unit |

## Verification
The bench checks the soft symbols against a model that holds every accepted chip and evaluates the conjugate inner product directly. The model also decides which unit owns each window from the symbol count alone. A wrong stagger, or a wrong order in the mux, would show up as soft symbols carrying the wrong index or the sum of a misaligned window. The bench uses each unit's first window after reset to catch a design that emits a half-filled window before 3L chips. It uses an unbalanced code with all-extreme samples and coefficients to catch a narrowed or rounded accumulator, which would show as a wrapped or biased value. Random idle gaps between chips, and a separate phase where only the anchor is active, expose gaps that advance the counters. They also expose a conjugation or sign slip in the centre third.

// File: rtl/despread_pkg.sv
package despread_pkg;
  localparam int NUM_UNITS = 3;
  typedef logic [1:0] unit_idx_t;

  // full-precision accumulator width: product + complex add + window growth
  function automatic int acc_width(input int samp_w, input int coef_w, input int win);
    return samp_w + (coef_w + 1) + 1 + $clog2(win);
  endfunction
endpackage

// File: rtl/despread_timer.sv
module despread_timer #(
  parameter int L = 16,
  localparam int CIDX_W = (L > 1) ? $clog2(L) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  output logic [CIDX_W-1:0] chip_idx_o,
  output logic [1:0]        sym_ph_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chip_idx_o <= '0;
      sym_ph_o   <= '0;
    end else if (en_i) begin
      if (chip_idx_o == CIDX_W'(L - 1)) begin
        chip_idx_o <= '0;
        sym_ph_o   <= (sym_ph_o == 2'd2) ? 2'd0 : sym_ph_o + 2'd1;
      end else begin
        chip_idx_o <= chip_idx_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/despread_coef_bank.sv
module despread_coef_bank #(
  parameter int L      = 16,
  parameter int COEF_W = 8,
  parameter int ANCHOR = 64,
  localparam int WIN   = 3 * L,
  localparam int POS_W = $clog2(WIN),
  localparam int HC_W  = COEF_W + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [L-1:0]             code_i,
  input  logic                     we_i,
  input  logic [POS_W-1:0]         addr_i,
  input  logic signed [COEF_W-1:0] wr_re_i,
  input  logic signed [COEF_W-1:0] wr_im_i,
  input  logic [POS_W-1:0]         pos_i  [despread_pkg::NUM_UNITS],
  output logic signed [HC_W-1:0]   h_re_o [despread_pkg::NUM_UNITS],
  output logic signed [HC_W-1:0]   h_im_o [despread_pkg::NUM_UNITS]
);
  logic signed [COEF_W-1:0] adapt_re [WIN];
  logic signed [COEF_W-1:0] adapt_im [WIN];
  logic signed [HC_W-1:0]   eff_re   [WIN];
  logic signed [HC_W-1:0]   eff_im   [WIN];

  for (genvar g = 0; g < WIN; g++) begin : g_pos
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        adapt_re[g] <= '0;
        adapt_im[g] <= '0;
      end else if (we_i && addr_i == POS_W'(g)) begin
        adapt_re[g] <= wr_re_i;
        adapt_im[g] <= wr_im_i;
      end
    end

    if (g >= L && g < 2 * L) begin : g_anchor
      assign eff_re[g] = HC_W'(adapt_re[g]) +
                         (code_i[g-L] ? -HC_W'(ANCHOR) : HC_W'(ANCHOR));
    end else begin : g_outer
      assign eff_re[g] = HC_W'(adapt_re[g]);
    end
    assign eff_im[g] = HC_W'(adapt_im[g]);
  end

  for (genvar n = 0; n < despread_pkg::NUM_UNITS; n++) begin : g_rd
    assign h_re_o[n] = eff_re[pos_i[n]];
    assign h_im_o[n] = eff_im[pos_i[n]];
  end
endmodule

// File: rtl/despread_mac.sv
module despread_mac #(
  parameter int SAMP_W = 8,
  parameter int HC_W   = 9,
  parameter int ACC_W  = 24
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     first_i,
  input  logic                     last_i,
  input  logic signed [SAMP_W-1:0] s_re_i,
  input  logic signed [SAMP_W-1:0] s_im_i,
  input  logic signed [HC_W-1:0]   h_re_i,
  input  logic signed [HC_W-1:0]   h_im_i,
  output logic                     done_o,
  output logic signed [ACC_W-1:0]  res_re_o,
  output logic signed [ACC_W-1:0]  res_im_o
);
  logic signed [ACC_W-1:0] sr, si, hr, hi, p_re, p_im, acc_re, acc_im;
  logic primed;

  assign sr = ACC_W'(s_re_i);
  assign si = ACC_W'(s_im_i);
  assign hr = ACC_W'(h_re_i);
  assign hi = ACC_W'(h_im_i);
  // conj(h) * y
  assign p_re = hr * sr + hi * si;
  assign p_im = hr * si - hi * sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_re   <= '0;
      acc_im   <= '0;
      primed   <= 1'b0;
      done_o   <= 1'b0;
      res_re_o <= '0;
      res_im_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (en_i) begin
        if (first_i) begin
          acc_re <= p_re;
          acc_im <= p_im;
          primed <= 1'b1;
        end else begin
          acc_re <= acc_re + p_re;
          acc_im <= acc_im + p_im;
        end
        // a window seen only in part since reset is discarded
        if (last_i && primed) begin
          done_o   <= 1'b1;
          res_re_o <= acc_re + p_re;
          res_im_o <= acc_im + p_im;
        end
      end
    end
  end
endmodule

// File: rtl/despread_out_mux.sv
module despread_out_mux #(
  parameter int ACC_W = 24
) (
  input  logic [despread_pkg::NUM_UNITS-1:0] done_i,
  input  logic signed [ACC_W-1:0]            re_i [despread_pkg::NUM_UNITS],
  input  logic signed [ACC_W-1:0]            im_i [despread_pkg::NUM_UNITS],
  output logic                               valid_o,
  output logic signed [ACC_W-1:0]            re_o,
  output logic signed [ACC_W-1:0]            im_o,
  output despread_pkg::unit_idx_t            unit_o
);
  always_comb begin
    valid_o = 1'b0;
    re_o    = '0;
    im_o    = '0;
    unit_o  = '0;
    for (int n = 0; n < despread_pkg::NUM_UNITS; n++) begin
      if (done_i[n]) begin
        valid_o = 1'b1;
        re_o    = re_i[n];
        im_o    = im_i[n];
        unit_o  = despread_pkg::unit_idx_t'(n);
      end
    end
  end
endmodule

// File: rtl/window_despreader.sv
module window_despreader #(
  parameter int L      = 16,
  parameter int SAMP_W = 8,
  parameter int COEF_W = 8,
  parameter int ANCHOR = 64,
  localparam int WIN    = 3 * L,
  localparam int POS_W  = $clog2(WIN),
  localparam int CIDX_W = (L > 1) ? $clog2(L) : 1,
  localparam int HC_W   = COEF_W + 1,
  localparam int ACC_W  = despread_pkg::acc_width(SAMP_W, COEF_W, WIN)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     chip_valid_i,
  input  logic signed [SAMP_W-1:0] chip_re_i,
  input  logic signed [SAMP_W-1:0] chip_im_i,
  input  logic [L-1:0]             code_i,
  input  logic                     coef_we_i,
  input  logic [POS_W-1:0]         coef_addr_i,
  input  logic signed [COEF_W-1:0] coef_re_i,
  input  logic signed [COEF_W-1:0] coef_im_i,
  output logic                     sym_valid_o,
  output logic signed [ACC_W-1:0]  sym_re_o,
  output logic signed [ACC_W-1:0]  sym_im_o,
  output logic [1:0]               sym_unit_o
);
  localparam int NU = despread_pkg::NUM_UNITS;

  logic [CIDX_W-1:0]       chip_idx;
  logic [1:0]              sym_ph;
  logic [POS_W-1:0]        pos    [NU];
  logic signed [HC_W-1:0]  h_re   [NU];
  logic signed [HC_W-1:0]  h_im   [NU];
  logic signed [ACC_W-1:0] res_re [NU];
  logic signed [ACC_W-1:0] res_im [NU];
  logic [NU-1:0]           unit_done;

  despread_timer #(.L(L)) u_timer (
    .clk_i, .rst_ni, .en_i(chip_valid_i),
    .chip_idx_o(chip_idx), .sym_ph_o(sym_ph)
  );

  despread_coef_bank #(.L(L), .COEF_W(COEF_W), .ANCHOR(ANCHOR)) u_coef (
    .clk_i, .rst_ni, .code_i,
    .we_i(coef_we_i), .addr_i(coef_addr_i),
    .wr_re_i(coef_re_i), .wr_im_i(coef_im_i),
    .pos_i(pos), .h_re_o(h_re), .h_im_o(h_im)
  );

  for (genvar n = 0; n < NU; n++) begin : g_unit
    logic [2:0] ph_sum;
    logic [1:0] off;
    // unit n opens its window on symbol phase n
    assign ph_sum = {1'b0, sym_ph} + 3'(3 - n);
    assign off    = (ph_sum >= 3'd3) ? 2'(ph_sum - 3'd3) : ph_sum[1:0];
    assign pos[n] = POS_W'(off) * POS_W'(L) + POS_W'(chip_idx);

    despread_mac #(.SAMP_W(SAMP_W), .HC_W(HC_W), .ACC_W(ACC_W)) u_mac (
      .clk_i, .rst_ni,
      .en_i(chip_valid_i),
      .first_i(pos[n] == '0),
      .last_i(pos[n] == POS_W'(WIN - 1)),
      .s_re_i(chip_re_i), .s_im_i(chip_im_i),
      .h_re_i(h_re[n]), .h_im_i(h_im[n]),
      .done_o(unit_done[n]),
      .res_re_o(res_re[n]), .res_im_o(res_im[n])
    );
  end

  despread_out_mux #(.ACC_W(ACC_W)) u_mux (
    .done_i(unit_done), .re_i(res_re), .im_i(res_im),
    .valid_o(sym_valid_o), .re_o(sym_re_o), .im_o(sym_im_o),
    .unit_o(sym_unit_o)
  );
endmodule

// File: rtl/window_despreader_chk.sv
module window_despreader_chk #(
  parameter int L = 16,
  localparam int WIN   = 3 * L,
  localparam int CNT_W = $clog2(WIN + 1)
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       chip_valid_i,
  input logic       sym_valid_i,
  input logic [1:0] sym_unit_i,
  input logic [2:0] unit_done_i
);
  logic [CNT_W-1:0] chip_cnt;
  logic [1:0]       last_unit;
  logic             seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chip_cnt  <= '0;
      last_unit <= '0;
      seen      <= 1'b0;
    end else begin
      if (chip_valid_i && chip_cnt != CNT_W'(WIN)) chip_cnt <= chip_cnt + 1'b1;
      if (sym_valid_i) begin
        last_unit <= sym_unit_i;
        seen      <= 1'b1;
      end
    end
  end

  assert_idle_reset_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !sym_valid_i);

  assert_full_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_i |-> chip_cnt == CNT_W'(WIN));

  assert_unit_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_i |-> sym_unit_i != 2'd3);

  assert_unit_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_i && seen) |-> sym_unit_i == ((last_unit == 2'd2) ? 2'd0 : last_unit + 2'd1));

  assert_single_unit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(unit_done_i));

  assert_gap_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chip_valid_i |=> !sym_valid_i);

  assert_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_i |=> !sym_valid_i);
endmodule

bind window_despreader window_despreader_chk #(.L(L)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .chip_valid_i(chip_valid_i),
  .sym_valid_i(sym_valid_o), .sym_unit_i(sym_unit_o), .unit_done_i(unit_done)
);

// File: tb/window_despreader_test.sv
module window_despreader_test;
  localparam int CLK_PERIOD = 10;
  localparam int L      = 16;
  localparam int SAMP_W = 8;
  localparam int COEF_W = 8;
  localparam int ANCHOR = 64;
  localparam int WIN    = 3 * L;
  localparam int POS_W  = $clog2(WIN);
  localparam int ACC_W  = despread_pkg::acc_width(SAMP_W, COEF_W, WIN);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic chip_valid = 1'b0;
  logic signed [SAMP_W-1:0] chip_re = '0, chip_im = '0;
  logic [L-1:0] code = '0;
  logic coef_we = 1'b0;
  logic [POS_W-1:0] coef_addr = '0;
  logic signed [COEF_W-1:0] coef_re = '0, coef_im = '0;
  logic sym_valid;
  logic signed [ACC_W-1:0] sym_re, sym_im;
  logic [1:0] sym_unit;

  int checks = 0;
  int errors = 0;
  int samp_r[$];
  int samp_q[$];
  int ad_re[WIN];
  int ad_im[WIN];
  string data_tag = "R3";

  window_despreader #(.L(L), .SAMP_W(SAMP_W), .COEF_W(COEF_W), .ANCHOR(ANCHOR)) uut (
    .clk_i(clk), .rst_ni, .chip_valid_i(chip_valid),
    .chip_re_i(chip_re), .chip_im_i(chip_im), .code_i(code),
    .coef_we_i(coef_we), .coef_addr_i(coef_addr),
    .coef_re_i(coef_re), .coef_im_i(coef_im),
    .sym_valid_o(sym_valid), .sym_re_o(sym_re), .sym_im_o(sym_im),
    .sym_unit_o(sym_unit)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic fail_msg(string tag, string what, longint act, longint exp);
    errors++;
    $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
  endtask

  task automatic check_idle(string tag);
    checks++;
    if (sym_valid !== 1'b0) fail_msg(tag, "sym_valid during idle", sym_valid, 0);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    chip_valid = 1'b0;
    coef_we = 1'b0;
    samp_r.delete();
    samp_q.delete();
    for (int p = 0; p < WIN; p++) begin ad_re[p] = 0; ad_im[p] = 0; end
    repeat (3) @(negedge clk);
    checks++;
    if (sym_valid !== 1'b0 || sym_re !== '0 || sym_im !== '0)
      fail_msg("R1", "outputs in reset", sym_valid, 0);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic write_coef(int p, int re, int im);
    coef_we = 1'b1;
    coef_addr = POS_W'(p);
    coef_re = COEF_W'(re);
    coef_im = COEF_W'(im);
    ad_re[p] = re;
    ad_im[p] = im;
    @(negedge clk);
    coef_we = 1'b0;
    check_idle("R7");
  endtask

  task automatic send_chip(int yr, int yq);
    int k, s, c;
    bit exp_v;
    longint er, ei;
    int eidx;
    chip_valid = 1'b1;
    chip_re = SAMP_W'(yr);
    chip_im = SAMP_W'(yq);
    samp_r.push_back(yr);
    samp_q.push_back(yq);
    k = samp_r.size() - 1;
    s = k / L;
    c = k % L;
    exp_v = (c == L - 1) && (s >= 2);
    er = 0; ei = 0; eidx = 0;
    if (exp_v) begin
      eidx = (s - 2) % 3;
      for (int p = 0; p < WIN; p++) begin
        longint hr, hi, y_r, y_q;
        y_r = samp_r[k - WIN + 1 + p];
        y_q = samp_q[k - WIN + 1 + p];
        hr = ad_re[p];
        hi = ad_im[p];
        if (p >= L && p < 2 * L) hr += code[p - L] ? -ANCHOR : ANCHOR;
        er += hr * y_r + hi * y_q;
        ei += hr * y_q - hi * y_r;
      end
    end
    @(negedge clk);
    chip_valid = 1'b0;
    checks++;
    if (sym_valid !== exp_v) begin
      fail_msg((k < WIN - 1) ? "R2" : "R8", "sym_valid", sym_valid, exp_v);
    end else if (exp_v) begin
      checks++;
      if (longint'(sym_re) != er) fail_msg(data_tag, "sym_re", sym_re, er);
      checks++;
      if (longint'(sym_im) != ei) fail_msg(data_tag, "sym_im", sym_im, ei);
      checks++;
      if (int'(sym_unit) != eidx) fail_msg("R4", "sym_unit", sym_unit, eidx);
    end
  endtask

  task automatic stream(int nsym, int mode, bit gaps);
    for (int i = 0; i < nsym * L; i++) begin
      int yr, yq;
      case (mode)
        0: begin yr = $urandom_range(0, 255) - 128; yq = $urandom_range(0, 255) - 128; end
        default: begin yr = -128; yq = -128; end
      endcase
      send_chip(yr, yq);
      if (gaps) begin
        int g = $urandom_range(0, 2);
        for (int j = 0; j < g; j++) begin
          @(negedge clk);
          check_idle("R7");
        end
      end
    end
  endtask

  initial begin
    void'($urandom(7));
    // R5: anchor only, balanced-ish code, no gaps
    code = 16'hA5C3;
    data_tag = "R5";
    do_reset();
    stream(10, 0, 1'b0);

    // R6 and R7: random adaptive part, gaps between chips
    code = 16'h3F01;
    data_tag = "R6";
    do_reset();
    for (int p = 0; p < WIN; p++)
      write_coef(p, $urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128);
    stream(12, 0, 1'b1);

    // R3: extremes with an unbalanced code, full word length
    code = '1;
    data_tag = "R3";
    do_reset();
    for (int p = 0; p < WIN; p++) write_coef(p, -128, -128);
    stream(8, 1, 1'b0);

    // R1: reset in mid-stream clears adaptive state, R2 again from scratch
    data_tag = "R1";
    do_reset();
    stream(5, 0, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule